// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps large, aligned regions of a 32-bit effective address space onto physical memory without walking a page table. It holds a small set of entries, each an upper word (effective block index, block-length mask, per-privilege valid bits) and a lower word (real block index, storage attributes, protection code). A lookup is purely combinational. It takes an effective address, a privilege flag and an access kind, and returns a hit, the physical address, the four storage attribute bits and a permission-fault flag.

Blocks range from 128 KiB to 256 MiB. An 11-bit contiguous low-order mask widens a block: every mask bit that is set drops one bit from the index comparison and lets the matching effective-address bit flow into the physical address. A chip uses one instance for instruction fetches and another for data accesses. On the instruction-side variant the guarded attribute is always reported as zero. A miss is left to the surrounding logic to resolve.

Top module: `bat_xlate`

## Requirements
- R1: After reset every entry is invalid. Every lookup then gives hit=0, fault=0, pa=0 and attr_wimg=0.
- R2: A write with wr_en=1 loads entry wr_idx on the rising clock edge. wr_hi=1 loads the upper word and wr_hi=0 loads the lower word. Upper word layout: [31:17] effective block index, [12:2] length mask, [1] supervisor-valid, [0] user-valid. Lower word layout: [31:17] real block index, [6:3] attributes in the order W,I,M,G (W at bit 6), [1:0] protection code. All other bits are ignored.
- R3: An entry is a candidate only if the valid bit for the current privilege is set (supervisor-valid when is_sup=1, user-valid otherwise) and ea[31:17] equals the stored effective index in every bit position whose mask bit is clear. The 11-bit mask covers index bits [10:0]; bits [14:11] are always compared.
- R4: On a hit, pa[31:17] = real index OR (ea[31:17] AND mask), and pa[16:0] = ea[16:0].
- R5: A mask of 0 gives a 128 KiB block. A mask of 0x7FF gives a 256 MiB block.
- R6: When several entries are candidates, the lowest-numbered one alone decides the result.
- R7: Protection code 0 faults on every access kind. Codes 1 and 3 allow reads and fetches and fault on writes. Code 2 allows every kind. acc_kind encodes 0 = read, 1 = write, 2 = fetch, and 3 is treated as a read.
- R8: A faulting lookup gives fault=1 and hit=0. A lookup with no candidate gives hit=0 and fault=0.
- R9: On a hit, attr_wimg reports the chosen entry's W,I,M,G bits as [3:0]. When INSN_SIDE=1 the guarded bit (attr_wimg[0]) is always zero.
- R10: When hit=0, pa and attr_wimg are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the entry write port |
| rst_n | input | 1 | Asynchronous active-low reset; clears every entry |
| wr_en | input | 1 | Entry write strobe |
| wr_hi | input | 1 | 1 selects the upper word, 0 the lower word |
| wr_idx | input | IDXW | Entry number written |
| wr_data | input | 32 | Word written |
| ea | input | 32 | Effective address to translate |
| is_sup | input | 1 | 1 = supervisor access, 0 = user access |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| hit | output | 1 | Translation succeeded |
| fault | output | 1 | The winning entry forbids this access |
| pa | output | 32 | Physical address, valid with hit |
| attr_wimg | output | 4 | Write-through, inhibit, coherent, guarded |

## Verification
The assertions sample the combinational lookup at each rising edge. They therefore assume that ea, is_sup and acc_kind are stable around that edge and are never X once reset is released. The bench changes these inputs only on falling edges and drives every one of them from the end of reset. The checks also assume that a software-style contiguous mask is written. The bench uses only low-order contiguous masks, and its own reference model applies the masking rule exactly as stated in R3, so any mask would still be compared fairly.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int AW     = 32;
  localparam int BIDX_W = 15;
  localparam int MSK_W  = 11;
  localparam int OFF_W  = AW - BIDX_W;

  typedef struct packed {
    logic [BIDX_W-1:0] eidx;
    logic [MSK_W-1:0]  len_mask;
    logic              sup_ok;
    logic              usr_ok;
  } blk_up_t;

  typedef struct packed {
    logic [BIDX_W-1:0] ridx;
    logic [3:0]        wimg;
    logic [1:0]        prot;
  } blk_lo_t;

  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_IF = 2'd2,
    ACC_RS = 2'd3
  } acc_e;

  function automatic logic [BIDX_W-1:0] wide_mask(logic [MSK_W-1:0] m);
    return {{(BIDX_W-MSK_W){1'b0}}, m};
  endfunction

  function automatic logic blk_match(blk_up_t u, logic [BIDX_W-1:0] ea_idx, logic sup);
    logic [BIDX_W-1:0] keep;
    keep = ~wide_mask(u.len_mask);
    return (sup ? u.sup_ok : u.usr_ok) && ((ea_idx & keep) == (u.eidx & keep));
  endfunction

  function automatic logic [BIDX_W-1:0] phys_idx(blk_lo_t l, blk_up_t u, logic [BIDX_W-1:0] ea_idx);
    return l.ridx | (ea_idx & wide_mask(u.len_mask));
  endfunction

  function automatic logic prot_denies(logic [1:0] prot, logic [1:0] kind);
    logic is_wr;
    is_wr = (kind == ACC_WR);
    return (prot == 2'd0) || (is_wr && (prot != 2'd2));
  endfunction
endpackage

// File: rtl/bat_regs.sv
module bat_regs
  import bat_pkg::*;
#(
  parameter int N_ENT     = 4,
  parameter bit INSN_SIDE = 1'b0,
  localparam int IDXW     = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_hi,
  input  logic [IDXW-1:0]        wr_idx,
  input  logic [AW-1:0]          wr_data,
  output blk_up_t [N_ENT-1:0]    ups,
  output blk_lo_t [N_ENT-1:0]    los
);
  logic    idx_ok;
  logic    guard_in;
  blk_up_t up_w;
  blk_lo_t lo_w;
  logic    unused_bits;

  assign idx_ok = (int'(wr_idx) < N_ENT);

  generate
    if (INSN_SIDE) begin : g_insn
      assign guard_in = 1'b0;
    end else begin : g_data
      assign guard_in = wr_data[3];
    end
  endgenerate

  assign up_w = '{eidx: wr_data[31:17], len_mask: wr_data[12:2],
                  sup_ok: wr_data[1], usr_ok: wr_data[0]};
  assign lo_w = '{ridx: wr_data[31:17], wimg: {wr_data[6:4], guard_in},
                  prot: wr_data[1:0]};
  assign unused_bits = ^{wr_data[16:13], wr_data[16:7], wr_data[2], wr_data[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ups <= '0;
      los <= '0;
    end else if (wr_en && idx_ok) begin
      if (wr_hi) ups[wr_idx] <= up_w;
      else       los[wr_idx] <= lo_w;
    end
  end
endmodule

// File: rtl/bat_match.sv
module bat_match
  import bat_pkg::*;
#(
  parameter int N_ENT = 4
) (
  input  blk_up_t [N_ENT-1:0] ups,
  input  logic [BIDX_W-1:0]   ea_idx,
  input  logic                is_sup,
  output logic [N_ENT-1:0]    match_vec
);
  generate
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      assign match_vec[e] = blk_match(ups[e], ea_idx, is_sup);
    end
  endgenerate
endmodule

// File: rtl/bat_pick.sv
module bat_pick
  import bat_pkg::*;
#(
  parameter int N_ENT = 4
) (
  input  blk_up_t [N_ENT-1:0] ups,
  input  blk_lo_t [N_ENT-1:0] los,
  input  logic [N_ENT-1:0]    match_vec,
  input  logic [AW-1:0]       ea,
  input  logic [1:0]          acc_kind,
  output logic [N_ENT-1:0]    win_vec,
  output logic                hit,
  output logic                fault,
  output logic [AW-1:0]       pa,
  output logic [3:0]          attr_wimg
);
  blk_up_t sel_up;
  blk_lo_t sel_lo;
  logic    any;
  logic    deny;

  always_comb begin
    win_vec = '0;
    sel_up  = '0;
    sel_lo  = '0;
    any     = 1'b0;
    for (int e = 0; e < N_ENT; e++) begin
      if (match_vec[e] && !any) begin
        any        = 1'b1;
        win_vec[e] = 1'b1;
        sel_up     = ups[e];
        sel_lo     = los[e];
      end
    end
  end

  assign deny  = any && prot_denies(sel_lo.prot, acc_kind);
  assign fault = deny;
  assign hit   = any && !deny;

  always_comb begin
    pa        = '0;
    attr_wimg = '0;
    if (hit) begin
      pa        = {phys_idx(sel_lo, sel_up, ea[AW-1:OFF_W]), ea[OFF_W-1:0]};
      attr_wimg = sel_lo.wimg;
    end
  end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int N_ENT     = 4,
  parameter bit INSN_SIDE = 1'b0,
  localparam int IDXW     = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_hi,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [31:0]     wr_data,
  input  logic [31:0]     ea,
  input  logic            is_sup,
  input  logic [1:0]      acc_kind,
  output logic            hit,
  output logic            fault,
  output logic [31:0]     pa,
  output logic [3:0]      attr_wimg
);
  blk_up_t [N_ENT-1:0] ups;
  blk_lo_t [N_ENT-1:0] los;
  logic [N_ENT-1:0]    match_vec;
  logic [N_ENT-1:0]    win_vec;

  bat_regs #(.N_ENT(N_ENT), .INSN_SIDE(INSN_SIDE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_idx(wr_idx), .wr_data(wr_data), .ups(ups), .los(los)
  );

  bat_match #(.N_ENT(N_ENT)) u_match (
    .ups(ups), .ea_idx(ea[AW-1:OFF_W]), .is_sup(is_sup), .match_vec(match_vec)
  );

  bat_pick #(.N_ENT(N_ENT)) u_pick (
    .ups(ups), .los(los), .match_vec(match_vec), .ea(ea), .acc_kind(acc_kind),
    .win_vec(win_vec), .hit(hit), .fault(fault), .pa(pa), .attr_wimg(attr_wimg)
  );
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk #(
  parameter int N_ENT     = 4,
  parameter bit INSN_SIDE = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hit,
  input logic             fault,
  input logic [31:0]      pa,
  input logic [3:0]       attr_wimg,
  input logic [N_ENT-1:0] match_vec,
  input logic [N_ENT-1:0] win_vec
);
  a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec));
  a_r6_winner_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vec & ~match_vec) == '0);
  a_r8_hit_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && fault));
  a_r8_no_candidate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec == '0) |-> (!hit && !fault));
  a_r3_hit_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (win_vec != '0));
  a_r10_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (pa == '0 && attr_wimg == '0));
  a_r9_insn_unguarded: assert property (@(posedge clk) disable iff (!rst_n)
    (INSN_SIDE && hit) |-> !attr_wimg[0]);
endmodule

bind bat_xlate bat_xlate_chk #(.N_ENT(N_ENT), .INSN_SIDE(INSN_SIDE)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .fault(fault), .pa(pa),
  .attr_wimg(attr_wimg), .match_vec(match_vec), .win_vec(win_vec)
);

// File: tb/bat_xlate_bench.sv
module bat_xlate_bench;
  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_hi = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0, ea = '0;
  logic        is_sup = 1'b0;
  logic [1:0]  acc_kind = 2'd0;
  logic        hit, fault, i_hit, i_fault;
  logic [31:0] pa, i_pa;
  logic [3:0]  attr_wimg, i_attr;
  logic        i_wr_en = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_up [NE];
  logic [31:0] m_lo [NE];

  always #4 clk = ~clk;

  bat_xlate #(.N_ENT(NE), .INSN_SIDE(1'b0)) u_bat_xlate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_idx(wr_idx),
    .wr_data(wr_data), .ea(ea), .is_sup(is_sup), .acc_kind(acc_kind),
    .hit(hit), .fault(fault), .pa(pa), .attr_wimg(attr_wimg)
  );

  bat_xlate #(.N_ENT(NE), .INSN_SIDE(1'b1)) u_bat_xlate_insn (
    .clk(clk), .rst_n(rst_n), .wr_en(i_wr_en), .wr_hi(wr_hi), .wr_idx(wr_idx),
    .wr_data(wr_data), .ea(ea), .is_sup(is_sup), .acc_kind(acc_kind),
    .hit(i_hit), .fault(i_fault), .pa(i_pa), .attr_wimg(i_attr)
  );

  function automatic logic [31:0] up_word(logic [14:0] ix, logic [10:0] m, logic s, logic u);
    return {ix, 4'b0, m, s, u};
  endfunction
  function automatic logic [31:0] lo_word(logic [14:0] rx, logic [3:0] a, logic [1:0] p);
    return {rx, 10'b0, a, 1'b0, p};
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic hi, int idx, logic [31:0] d, logic insn = 1'b0);
    @(negedge clk);
    wr_hi = hi; wr_idx = 2'(idx); wr_data = d;
    if (insn) i_wr_en = 1'b1; else wr_en = 1'b1;
    if (!insn) begin
      if (hi) m_up[idx] = d; else m_lo[idx] = d;
    end
    @(negedge clk);
    wr_en = 1'b0; i_wr_en = 1'b0;
  endtask

  // Reference lookup built from R3, R4, R6, R7, R8, R10
  task automatic lookup(string req, logic [31:0] a, logic sup, logic [1:0] k);
    logic e_hit, e_flt;
    logic [31:0] e_pa;
    logic [3:0] e_at;
    logic found;
    e_hit = 0; e_flt = 0; e_pa = 0; e_at = 0; found = 0;
    for (int e = 0; e < NE; e++) begin
      logic [14:0] msk;
      logic vld;
      msk = {4'b0, m_up[e][12:2]};
      vld = sup ? m_up[e][1] : m_up[e][0];
      if (!found && vld && ((a[31:17] | msk) == (m_up[e][31:17] | msk))) begin
        found = 1;
        if (m_lo[e][1:0] == 2'd0 || (k == 2'd1 && m_lo[e][1:0] != 2'd2)) e_flt = 1;
        else begin
          e_hit = 1;
          e_pa  = {m_lo[e][31:17] | (a[31:17] & msk), a[16:0]};
          e_at  = m_lo[e][6:3];
        end
      end
    end
    @(negedge clk);
    ea = a; is_sup = sup; acc_kind = k;
    #1;
    check(req, "hit", 64'(hit), 64'(e_hit));
    check(req, "fault", 64'(fault), 64'(e_flt));
    check(req, "pa", 64'(pa), 64'(e_pa));
    check(req, "attr", 64'(attr_wimg), 64'(e_at));
  endtask

  task automatic t_reset;
    lookup("R1", 32'h1000_0000, 1'b1, 2'd0);
    check("R1", "pa after reset", 64'(pa), 64'h0);
    check("R1", "insn hit after reset", 64'(i_hit), 64'h0);
  endtask

  task automatic t_small_block;
    wr(1'b1, 0, up_word(15'h0800, 11'h000, 1'b1, 1'b0));
    wr(1'b0, 0, lo_word(15'h0123, 4'b0101, 2'd2));
    lookup("R4", 32'h1001_2345, 1'b1, 2'd0);
    check("R4", "pa literal", 64'(pa), 64'h0247_2345);
    check("R9", "attr literal", 64'(attr_wimg), 64'h5);
    lookup("R3", 32'h1001_2345, 1'b0, 2'd0);
    check("R3", "user denied by valid bit", 64'(hit), 64'h0);
    lookup("R5", 32'h1002_0000, 1'b1, 2'd0);
    check("R5", "128K boundary miss", 64'(hit), 64'h0);
    lookup("R5", 32'h1001_FFFF, 1'b1, 2'd1);
    check("R7", "write to rw block", 64'(hit), 64'h1);
  endtask

  task automatic t_big_block;
    wr(1'b1, 1, up_word(15'h4000, 11'h7FF, 1'b1, 1'b1));
    wr(1'b0, 1, lo_word(15'h2000, 4'b1010, 2'd1));
    lookup("R5", 32'h8FFF_FFF0, 1'b0, 2'd0);
    check("R5", "256M pa literal", 64'(pa), 64'h4FFF_FFF0);
    lookup("R5", 32'h9000_0000, 1'b1, 2'd0);
    check("R5", "beyond 256M miss", 64'(hit), 64'h0);
    lookup("R7", 32'h8000_1000, 1'b1, 2'd1);
    check("R8", "write ro faults", 64'(fault), 64'h1);
    lookup("R7", 32'h8000_1000, 1'b1, 2'd2);
    lookup("R7", 32'h8000_1000, 1'b1, 2'd3);
  endtask

  task automatic t_priority;
    wr(1'b1, 3, up_word(15'h0800, 11'h003, 1'b1, 1'b1));
    wr(1'b0, 3, lo_word(15'h7000, 4'b0011, 2'd2));
    lookup("R6", 32'h1000_0040, 1'b1, 2'd0);
    check("R6", "entry 0 wins", 64'(pa), 64'h0246_0040);
    lookup("R6", 32'h1000_0040, 1'b0, 2'd0);
    check("R6", "entry 3 for user", 64'(pa), 64'hE000_0040);
    wr(1'b1, 0, up_word(15'h0800, 11'h000, 1'b0, 1'b0));
    lookup("R6", 32'h1004_0000, 1'b1, 2'd0);
    check("R6", "masked bit flows through", 64'(pa), 64'hE004_0000);
    wr(1'b0, 2, lo_word(15'h0001, 4'b1111, 2'd0));
    wr(1'b1, 2, up_word(15'h0000, 11'h000, 1'b1, 1'b1));
    lookup("R7", 32'h0000_0100, 1'b1, 2'd0);
    check("R7", "prot 0 read faults", 64'(fault), 64'h1);
    wr(1'b0, 2, lo_word(15'h0001, 4'b1111, 2'd3));
    lookup("R7", 32'h0000_0100, 1'b1, 2'd0);
    check("R7", "prot 3 read ok", 64'(hit), 64'h1);
    lookup("R7", 32'h0000_0100, 1'b1, 2'd1);
    check("R7", "prot 3 write faults", 64'(fault), 64'h1);
  endtask

  task automatic t_ignored_bits;
    wr(1'b1, 2, 32'h0001_E000 | up_word(15'h0000, 11'h000, 1'b1, 1'b1));
    lookup("R2", 32'h0000_0200, 1'b1, 2'd0);
    check("R2", "reserved upper bits ignored", 64'(pa), 64'h0002_0200);
  endtask

  task automatic t_insn_guard;
    wr(1'b1, 1, up_word(15'h0020, 11'h000, 1'b1, 1'b1), 1'b1);
    wr(1'b0, 1, lo_word(15'h0030, 4'b0111, 2'd2), 1'b1);
    @(negedge clk);
    ea = 32'h0040_0010; is_sup = 1'b1; acc_kind = 2'd2;
    #1;
    check("R9", "insn hit", 64'(i_hit), 64'h1);
    check("R9", "insn guarded forced 0", 64'(i_attr), 64'h6);
    check("R4", "insn pa", 64'(i_pa), 64'h0060_0010);
  endtask

  initial begin
    for (int e = 0; e < NE; e++) begin m_up[e] = '0; m_lo[e] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_small_block();
    t_big_block();
    t_priority();
    t_ignored_bits();
    t_insn_guard();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule